// File: doc/BRIEF.md
# Epoch-Based Pipeline Redirect Controller

This block works alongside a three-stage fetch, decode and execute pipeline and decides which in-flight instructions are on a wrong path. It owns the fetch program counter and two epoch counters, one for each stage that may steer fetch. Every instruction that leaves fetch takes a copy of both counters as tags. Later stages present those tags back to the block, and the block tells them whether the instruction must be dropped.

Decode may request a redirect, for example after a predictor disagrees with the fetched path. Execute may request one after it resolves a branch. When both ask in the same cycle, the execute request is taken and the decode request is dropped. An accepted redirect loads the new target into the fetch PC at the next clock edge and advances the requesting stage's epoch at that same edge. Any instruction fetched under the old epoch is then recognised as stale and removed further down the pipeline. A redirect raised by an instruction that is itself stale never reaches the PC.

Top module: `redirect_ctrl`

## Requirements
- R1: While reset is held and at the first cycle after it, `fetch_pc` equals the RESET_PC parameter and both epoch outputs are zero.
- R2: With no redirect taken, a cycle with `fetch_fire` high advances `fetch_pc` by 4 and a cycle with it low leaves `fetch_pc` unchanged.
- R3: `fetch_dep` and `fetch_eep` always show the current decode and execute epochs, which are the tags an instruction fetched in that cycle carries.
- R4: `dec_kill` is high exactly when `dec_valid` is high and `dec_etag` differs from the current execute epoch. A killed decode instruction never produces `dec_redir_taken`.
- R5: A decode request whose `dec_dtag` differs from the current decode epoch is not taken and leaves the PC and both epochs unchanged.
- R6: A decode request from a live instruction with a current decode tag and no execute redirect in that cycle raises `dec_redir_taken`. At the next edge `fetch_pc` becomes `dec_target`, the decode epoch increments and the execute epoch holds.
- R7: `exe_kill` is high exactly when `exe_valid` is high and `exe_etag` differs from the current execute epoch. A killed execute instruction never produces `exe_redir_taken`.
- R8: An execute request from a live instruction raises `exe_redir_taken`. At the next edge `fetch_pc` becomes `exe_target`, the execute epoch increments and the decode epoch holds.
- R9: When both stages have a redirect eligible in the same cycle, only the execute one is taken. `dec_redir_taken` stays low and the decode epoch does not change.
- R10: Epochs are EPOCH_W-bit counters that wrap from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_fire | input | 1 | Fetch issues an instruction this cycle |
| fetch_pc | output | ADDR_W | Address fetch uses this cycle |
| fetch_dep | output | EPOCH_W | Decode epoch tag for the instruction fetched now |
| fetch_eep | output | EPOCH_W | Execute epoch tag for the instruction fetched now |
| dec_valid | input | 1 | An instruction occupies decode |
| dec_dtag | input | EPOCH_W | Decode epoch tag of that instruction |
| dec_etag | input | EPOCH_W | Execute epoch tag of that instruction |
| dec_redir_req | input | 1 | Decode asks to redirect fetch |
| dec_target | input | ADDR_W | Decode redirect target |
| dec_kill | output | 1 | Decode instruction is stale and must be dropped |
| dec_redir_taken | output | 1 | Decode redirect accepted this cycle |
| exe_valid | input | 1 | An instruction occupies execute |
| exe_etag | input | EPOCH_W | Execute epoch tag of that instruction |
| exe_redir_req | input | 1 | Execute asks to redirect fetch |
| exe_target | input | ADDR_W | Execute redirect target |
| exe_kill | output | 1 | Execute instruction is stale and must be dropped |
| exe_redir_taken | output | 1 | Execute redirect accepted this cycle |

## Verification
The bench builds the block with EPOCH_W = 2 and ADDR_W = 16. With only four epoch values, a sweep over every combination of valid bits, request bits and the three incoming tags hits matching and stale tags often. It also hits both-stages-at-once conflicts, and it wraps both epochs many times within a couple of thousand cycles. The narrow address lets the PC model use plain 16-bit arithmetic.

// File: rtl/redirect_pkg.sv
package redirect_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DEC  = 2'd1,
        SRC_EXE  = 2'd2
    } redir_src_e;

    localparam int INSTR_BYTES = 4;

    // Execute always outranks decode.
    function automatic redir_src_e pick_src(input logic exe_ok, input logic dec_ok);
        if (exe_ok)      return SRC_EXE;
        else if (dec_ok) return SRC_DEC;
        else             return SRC_NONE;
    endfunction

endpackage

// File: rtl/epoch_ctr.sv
module epoch_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bump,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (bump) value <= value + 1'b1;
    end
endmodule

// File: rtl/stage_gate.sv
module stage_gate #(
    parameter int W = 4
) (
    input  logic         valid,
    input  logic         req,
    input  logic [W-1:0] etag,
    input  logic [W-1:0] cur_e,
    input  logic [W-1:0] dtag,
    input  logic [W-1:0] cur_d,
    output logic         kill,
    output logic         redir_ok
);
    logic e_stale;
    logic d_fresh;

    always_comb begin
        e_stale  = (etag != cur_e);
        d_fresh  = (dtag == cur_d);
        kill     = valid && e_stale;
        redir_ok = valid && !e_stale && d_fresh && req;
    end
endmodule

// File: rtl/redirect_arb.sv
module redirect_arb
    import redirect_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          exe_ok,
    input  logic          dec_ok,
    input  logic [AW-1:0] exe_pc,
    input  logic [AW-1:0] dec_pc,
    output redir_src_e    src,
    output logic          exe_taken,
    output logic          dec_taken,
    output logic [AW-1:0] target
);
    always_comb begin
        src       = pick_src(exe_ok, dec_ok);
        exe_taken = (src == SRC_EXE);
        dec_taken = (src == SRC_DEC);
        unique case (src)
            SRC_EXE: target = exe_pc;
            SRC_DEC: target = dec_pc;
            default: target = '0;
        endcase
    end
endmodule

// File: rtl/redirect_ctrl.sv
module redirect_ctrl
    import redirect_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          EPOCH_W  = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_fire,
    output logic [ADDR_W-1:0]  fetch_pc,
    output logic [EPOCH_W-1:0] fetch_dep,
    output logic [EPOCH_W-1:0] fetch_eep,
    input  logic               dec_valid,
    input  logic [EPOCH_W-1:0] dec_dtag,
    input  logic [EPOCH_W-1:0] dec_etag,
    input  logic               dec_redir_req,
    input  logic [ADDR_W-1:0]  dec_target,
    output logic               dec_kill,
    output logic               dec_redir_taken,
    input  logic               exe_valid,
    input  logic [EPOCH_W-1:0] exe_etag,
    input  logic               exe_redir_req,
    input  logic [ADDR_W-1:0]  exe_target,
    output logic               exe_kill,
    output logic               exe_redir_taken
);
    localparam int NSTAGE = 2;
    localparam int ST_DEC = 0;
    localparam int ST_EXE = 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic [EPOCH_W-1:0] epoch [NSTAGE];
    logic [NSTAGE-1:0]  bump;
    logic               dec_ok;
    logic               exe_ok;
    redir_src_e         src;
    logic [ADDR_W-1:0]  redir_pc;
    logic [ADDR_W-1:0]  pc_q;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_epoch
        epoch_ctr #(.W(EPOCH_W)) u_ctr (
            .clk  (clk),
            .rst  (rst),
            .bump (bump[g]),
            .value(epoch[g])
        );
    end

    stage_gate #(.W(EPOCH_W)) u_dec_gate (
        .valid   (dec_valid),
        .req     (dec_redir_req),
        .etag    (dec_etag),
        .cur_e   (epoch[ST_EXE]),
        .dtag    (dec_dtag),
        .cur_d   (epoch[ST_DEC]),
        .kill    (dec_kill),
        .redir_ok(dec_ok)
    );

    // Execute does not judge by decode epoch: its decode comparison is tied true.
    stage_gate #(.W(EPOCH_W)) u_exe_gate (
        .valid   (exe_valid),
        .req     (exe_redir_req),
        .etag    (exe_etag),
        .cur_e   (epoch[ST_EXE]),
        .dtag    (epoch[ST_DEC]),
        .cur_d   (epoch[ST_DEC]),
        .kill    (exe_kill),
        .redir_ok(exe_ok)
    );

    redirect_arb #(.AW(ADDR_W)) u_arb (
        .exe_ok   (exe_ok),
        .dec_ok   (dec_ok),
        .exe_pc   (exe_target),
        .dec_pc   (dec_target),
        .src      (src),
        .exe_taken(exe_redir_taken),
        .dec_taken(dec_redir_taken),
        .target   (redir_pc)
    );

    always_comb begin
        bump[ST_DEC] = dec_redir_taken;
        bump[ST_EXE] = exe_redir_taken;
    end

    always_ff @(posedge clk) begin
        if (rst)                 pc_q <= RESET_PC;
        else if (src != SRC_NONE) pc_q <= redir_pc;
        else if (fetch_fire)     pc_q <= pc_q + STEP;
    end

    assign fetch_pc  = pc_q;
    assign fetch_dep = epoch[ST_DEC];
    assign fetch_eep = epoch[ST_EXE];
endmodule

// File: rtl/redirect_ctrl_chk.sv
module redirect_ctrl_chk #(
    parameter int ADDR_W  = 32,
    parameter int EPOCH_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               fetch_fire,
    input logic [ADDR_W-1:0]  fetch_pc,
    input logic [EPOCH_W-1:0] fetch_dep,
    input logic [EPOCH_W-1:0] fetch_eep,
    input logic               dec_kill,
    input logic               dec_redir_taken,
    input logic [ADDR_W-1:0]  dec_target,
    input logic               exe_kill,
    input logic               exe_redir_taken,
    input logic [ADDR_W-1:0]  exe_target
);
    // R9
    exe_wins_chk: assert property (@(posedge clk) disable iff (rst)
        exe_redir_taken |-> !dec_redir_taken);

    // R4
    dec_kill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dec_kill |-> !dec_redir_taken);

    // R7
    exe_kill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        exe_kill |-> !exe_redir_taken);

    // R8
    exe_pc_load_chk: assert property (@(posedge clk) disable iff (rst)
        exe_redir_taken |=> fetch_pc == $past(exe_target));

    // R8
    exe_epoch_step_chk: assert property (@(posedge clk) disable iff (rst)
        exe_redir_taken |=> (fetch_eep == $past(fetch_eep) + 1'b1) && $stable(fetch_dep));

    // R6
    dec_epoch_step_chk: assert property (@(posedge clk) disable iff (rst)
        dec_redir_taken |=> (fetch_dep == $past(fetch_dep) + 1'b1) && $stable(fetch_eep)
                            && fetch_pc == $past(dec_target));

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!exe_redir_taken && !dec_redir_taken && !fetch_fire) |=> $stable(fetch_pc));
endmodule

bind redirect_ctrl redirect_ctrl_chk #(.ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fetch_fire     (fetch_fire),
    .fetch_pc       (fetch_pc),
    .fetch_dep      (fetch_dep),
    .fetch_eep      (fetch_eep),
    .dec_kill       (dec_kill),
    .dec_redir_taken(dec_redir_taken),
    .dec_target     (dec_target),
    .exe_kill       (exe_kill),
    .exe_redir_taken(exe_redir_taken),
    .exe_target     (exe_target)
);

// File: tb/tb_redirect_ctrl.sv
`timescale 1ns/1ps
module tb_redirect_ctrl;
    localparam int EW = 2;
    localparam int AW = 16;
    localparam logic [AW-1:0] RPC = 16'h0200;

    logic          clk = 1'b0;
    logic          rst;
    logic          fetch_fire;
    logic [AW-1:0] fetch_pc;
    logic [EW-1:0] fetch_dep, fetch_eep;
    logic          dec_valid, dec_redir_req, dec_kill, dec_redir_taken;
    logic [EW-1:0] dec_dtag, dec_etag;
    logic [AW-1:0] dec_target;
    logic          exe_valid, exe_redir_req, exe_kill, exe_redir_taken;
    logic [EW-1:0] exe_etag;
    logic [AW-1:0] exe_target;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [AW-1:0] m_pc;
    logic [EW-1:0] m_de, m_ee;
    bit            wrapped;

    always #2.5 clk = ~clk;

    redirect_ctrl #(.ADDR_W(AW), .EPOCH_W(EW), .RESET_PC(RPC)) dut (
        .clk(clk), .rst(rst), .fetch_fire(fetch_fire),
        .fetch_pc(fetch_pc), .fetch_dep(fetch_dep), .fetch_eep(fetch_eep),
        .dec_valid(dec_valid), .dec_dtag(dec_dtag), .dec_etag(dec_etag),
        .dec_redir_req(dec_redir_req), .dec_target(dec_target),
        .dec_kill(dec_kill), .dec_redir_taken(dec_redir_taken),
        .exe_valid(exe_valid), .exe_etag(exe_etag),
        .exe_redir_req(exe_redir_req), .exe_target(exe_target),
        .exe_kill(exe_kill), .exe_redir_taken(exe_redir_taken)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check, then advance the model at posedge.
    task automatic step(input bit ff, input bit dv, input bit dr, input logic [EW-1:0] dtd,
                        input logic [EW-1:0] dte, input logic [AW-1:0] dtg,
                        input bit ev, input bit er, input logic [EW-1:0] ete,
                        input logic [AW-1:0] etg);
        bit e_dk, e_ek, e_et, e_dt;
        @(negedge clk);
        fetch_fire = ff; dec_valid = dv; dec_redir_req = dr; dec_dtag = dtd;
        dec_etag = dte; dec_target = dtg; exe_valid = ev; exe_redir_req = er;
        exe_etag = ete; exe_target = etg;
        #1;
        chk(wrapped ? "R10" : "R2", "fetch_pc", int'(fetch_pc), int'(m_pc));
        chk(wrapped ? "R10" : "R3", "fetch_dep", int'(fetch_dep), int'(m_de));
        chk(wrapped ? "R10" : "R3", "fetch_eep", int'(fetch_eep), int'(m_ee));
        e_dk = dv && (dte != m_ee);
        e_ek = ev && (ete != m_ee);
        e_et = ev && !e_ek && er;
        e_dt = dv && !e_dk && dr && (dtd == m_de) && !e_et;
        chk("R4", "dec_kill", int'(dec_kill), int'(e_dk));
        chk("R7", "exe_kill", int'(exe_kill), int'(e_ek));
        chk("R8", "exe_redir_taken", int'(exe_redir_taken), int'(e_et));
        if (dv && !e_dk && dr && dtd == m_de && e_et)
            chk("R9", "dec_redir_taken", int'(dec_redir_taken), 0);
        else if (dv && !e_dk && dr && dtd != m_de)
            chk("R5", "dec_redir_taken", int'(dec_redir_taken), 0);
        else
            chk("R6", "dec_redir_taken", int'(dec_redir_taken), int'(e_dt));
        @(posedge clk);
        wrapped = 1'b0;
        if (e_et) begin
            m_pc = etg;
            wrapped = (m_ee == '1);
            m_ee = m_ee + 1'b1;
        end else if (e_dt) begin
            m_pc = dtg;
            wrapped = (m_de == '1);
            m_de = m_de + 1'b1;
        end else if (ff) begin
            m_pc = m_pc + 16'd4;
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fetch_fire = 0; dec_valid = 0; dec_redir_req = 0; dec_dtag = 0;
        dec_etag = 0; dec_target = 0; exe_valid = 0; exe_redir_req = 0; exe_etag = 0;
        exe_target = 0;
        m_pc = RPC; m_de = '0; m_ee = '0; wrapped = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values held during reset
        chk("R1", "fetch_pc in reset", int'(fetch_pc), int'(RPC));
        chk("R1", "fetch_dep in reset", int'(fetch_dep), 0);
        chk("R1", "fetch_eep in reset", int'(fetch_eep), 0);
        rst = 1'b0;
        @(posedge clk);
        // R1: first cycle after reset is covered by the first step's checks
        step(1'b0, 0, 0, 0, 0, 16'h0, 0, 0, 0, 16'h0);
        step(1'b1, 0, 0, 0, 0, 16'h0, 0, 0, 0, 16'h0);
        step(1'b1, 0, 0, 0, 0, 16'h0, 0, 0, 0, 16'h0);
        // R9: directed conflict with both eligible
        step(1'b1, 1, 1, m_de, m_ee, 16'h3330, 1, 1, m_ee, 16'h4440);
        // R6 then R8 directed
        step(1'b0, 1, 1, m_de, m_ee, 16'h1000, 0, 0, 0, 16'h0);
        step(1'b0, 0, 0, 0, 0, 16'h0, 1, 1, m_ee, 16'h2000);
        // Exhaustive sweep over control bits and the three tags, two passes.
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 1024; i++) begin
                logic [9:0] v;
                v = 10'(i);
                step(v[0] ^ v[3] ^ pass[0], v[0], v[1], v[5:4], v[7:6],
                     16'(16'h8000 + i * 4), v[2], v[3], v[9:8],
                     16'(16'hC000 + i * 8 + pass * 4));
            end
        end
        step(1'b0, 0, 0, 0, 0, 16'h0, 0, 0, 0, 16'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule